// File: doc/BRIEF.md
# Single-Request Interrupt Concentrator

The block collects 64 level-sensitive interrupt lines and reduces them to a single outstanding request. That request appears as one bit of a one-hot output vector. The lower 32 lines come from bus slots. They share enables in groups of four, with one mapping entry per group. The upper 32 lines are on-board sources, and each has its own mapping entry. Only one source can be requested at a time. A rising edge on an enabled slot line takes over the request at once. A rising edge on an on-board line is accepted only while the block is idle.

Software uses a small register port to program the enable bit of each mapping entry. The same port retires the current request, through a per-group slot clear register or a per-source on-board clear register. After a map write or a clear that retires the request, the block re-arbitrates if it is left idle. It scans the sampled input levels in ascending source order, so every slot source comes before every on-board source, and picks the first source whose entry is enabled. Writing an entry with its enable bit cleared drops the request of the source that entry governs. Each register sits at an 8-byte stride, and only the upper word (address bit 2 set) carries data.

Top module: `irq_concentrator`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_vec` is all zero. Reset clears every enable bit and every sampled input level, and it leaves the fixed low bits of each map entry unchanged.
- R2: `reg_addr[11:8]` selects the region. Region 0 holds the slot map, indexed by `reg_addr[5:3]`; region 1 holds the on-board map, indexed by `reg_addr[7:3]`. An upper-word read returns the entry's enable in bit 31 and a fixed value in bits 30:0: 0x7C0 + 4*g for slot group g, and 0x7E0 + j for on-board entry j. A write loads bit 31 from `reg_wdata[31]` and leaves bits 30:0 unchanged.
- R3: When `reg_addr[2]` is 0, reads return zero and writes have no effect on any register or on the request.
- R4: Slot source i (0 to 31) is governed by slot entry i/4. A rising edge on that source (high now, low in the previous cycle) while its entry is enabled makes i the request from the next cycle on. The new request replaces any outstanding one. The enable used is its value before any write in the same cycle. When several slot sources rise together, the lowest index wins.
- R5: On-board source 32+j is governed by on-board entry j. Its enabled rising edge becomes the request only if no request remains after that cycle's register effects and no slot source wins under R4.
- R6: At most one bit of `req_vec` is high. The request holds until it is retired, even if its input falls.
- R7: An upper-word write to region 2 with index `reg_addr[7:5]` retires the request if the request is a slot source i with i/4 equal to the index. Otherwise the write has no effect.
- R8: An upper-word write to region 3 with index `reg_addr[7:3]` retires the request if the request is source 32 plus the index. Otherwise the write has no effect.
- R9: A map write with `reg_wdata[31]` = 0 to the entry that governs the requested source drops the request.
- R10: After any map write, and after any clear that retires the request, the block re-arbitrates if no request remains. It requests the lowest-numbered source whose input was high in the previous cycle and whose entry is enabled after the write. If there is none, the block stays idle.
- R11: Region 4 holds two read-only error entries, indexed by `reg_addr[3]`, which read 0x7F0. Writes to them are ignored.
- R12: Bit k of `req_vec` is high exactly when source k holds the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines, slots at 31:0, on-board at 63:32 |
| reg_wr | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data; only bit 31 is stored |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| req_vec | output | 64 | One-hot outstanding request, zero when idle |

## Verification
A single rising slot line shows the basic capture. A second slot line rising over it separates take-over from first-come behaviour. The same test with an on-board line shows that on-board edges wait while the block is busy. Clear writes with a matching index are checked against writes with a neighbouring index, which must have no effect. Some of these writes are made while the retired source is still high, which shows that re-arbitration reads the sampled levels rather than edges. A disable write to the entry that governs the request is set against a write to the lower word at the same entry's address. The first must drop the request; the second must not.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int REG_AW     = 12;
   localparam int DATA_W     = 32;
   localparam int LOW_W      = DATA_W - 1;
   localparam int REGION_LSB = 8;
   localparam int STRIDE_LSB = 3;
   localparam int UPPER_BIT  = 2;
   localparam int EN_BIT     = DATA_W - 1;

   localparam logic [LOW_W-1:0] SLOT_FIXED  = 31'h7C0;
   localparam logic [LOW_W-1:0] BOARD_FIXED = 31'h7E0;
   localparam logic [LOW_W-1:0] ERR_FIXED   = 31'h7F0;

   typedef enum logic [REG_AW-REGION_LSB-1:0] {
      RG_SLOT_MAP  = 4'h0,
      RG_BOARD_MAP = 4'h1,
      RG_SLOT_CLR  = 4'h2,
      RG_BOARD_CLR = 4'h3,
      RG_ERR_MAP   = 4'h4
   } region_e;

   typedef struct packed {
      logic slot_map;
      logic board_map;
      logic slot_clr;
      logic board_clr;
   } wr_event_t;
endpackage

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
   parameter int W = 64,
   localparam int XW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [XW-1:0] idx
);
   generate
      if (W < 2) begin : g_bad_w
         $error("irqc_first_set: W must be at least 2");
      end
   endgenerate

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = XW'(i);
      end
   end
endmodule

// File: rtl/irqc_onehot.sv
module irqc_onehot #(
   parameter int N  = 64,
   parameter int IW = 7
) (
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  vec
);
   generate
      if ((1 << IW) <= N) begin : g_bad_iw
         $error("irqc_onehot: IW too narrow for an idle code");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign vec[i] = (idx == IW'(i));
      end
   endgenerate
endmodule

// File: rtl/irqc_regbank.sv
module irqc_regbank
   import irqc_pkg::*;
#(
   parameter int N_SGRP  = 8,
   parameter int N_BOARD = 32,
   parameter int GRP     = 4,
   localparam int SGW    = $clog2(N_SGRP),
   localparam int BW     = $clog2(N_BOARD),
   localparam int GW     = $clog2(GRP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              wr_en_bit,
   output logic [DATA_W-1:0] rdata,
   output wr_event_t         ev,
   output logic [SGW-1:0]    idx_sm,
   output logic [BW-1:0]     idx_bm,
   output logic [SGW-1:0]    idx_sc,
   output logic [BW-1:0]     idx_bc,
   output logic [N_SGRP-1:0]  slot_en_q,
   output logic [N_SGRP-1:0]  slot_en_nx,
   output logic [N_BOARD-1:0] board_en_q,
   output logic [N_BOARD-1:0] board_en_nx
);
   localparam int SCL = STRIDE_LSB + GW;

   generate
      if (N_SGRP < 2 || N_BOARD < 2 || GRP < 2) begin : g_bad_small
         $error("irqc_regbank: group count, board count and group size must be >= 2");
      end
      if ((1 << SGW) != N_SGRP || (1 << BW) != N_BOARD || (1 << GW) != GRP) begin : g_bad_pow2
         $error("irqc_regbank: counts must be powers of two");
      end
      if (STRIDE_LSB + BW > REGION_LSB || SCL + SGW > REGION_LSB) begin : g_bad_fit
         $error("irqc_regbank: index fields overflow the region window");
      end
   endgenerate

   region_e rg;
   logic    upper;
   logic    wr_live;
   logic    unused_addr;

   assign rg          = region_e'(reg_addr[REG_AW-1:REGION_LSB]);
   assign upper       = reg_addr[UPPER_BIT];
   assign wr_live     = reg_wr && upper;
   assign unused_addr = ^reg_addr[UPPER_BIT-1:0];

   assign idx_sm = reg_addr[STRIDE_LSB +: SGW];
   assign idx_bm = reg_addr[STRIDE_LSB +: BW];
   assign idx_sc = reg_addr[SCL +: SGW];
   assign idx_bc = reg_addr[STRIDE_LSB +: BW];

   assign ev.slot_map  = wr_live && (rg == RG_SLOT_MAP);
   assign ev.board_map = wr_live && (rg == RG_BOARD_MAP);
   assign ev.slot_clr  = wr_live && (rg == RG_SLOT_CLR);
   assign ev.board_clr = wr_live && (rg == RG_BOARD_CLR);

   generate
      for (genvar g = 0; g < N_SGRP; g++) begin : g_slot_en
         assign slot_en_nx[g] = (ev.slot_map && idx_sm == SGW'(g)) ? wr_en_bit : slot_en_q[g];
      end
      for (genvar j = 0; j < N_BOARD; j++) begin : g_board_en
         assign board_en_nx[j] = (ev.board_map && idx_bm == BW'(j)) ? wr_en_bit : board_en_q[j];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_en_q  <= '0;
         board_en_q <= '0;
      end else begin
         slot_en_q  <= slot_en_nx;
         board_en_q <= board_en_nx;
      end
   end

   always_comb begin
      rdata = '0;
      if (upper) begin
         case (rg)
            RG_SLOT_MAP:  rdata = {slot_en_q[idx_sm], SLOT_FIXED | (LOW_W'(idx_sm) * LOW_W'(GRP))};
            RG_BOARD_MAP: rdata = {board_en_q[idx_bm], BOARD_FIXED + LOW_W'(idx_bm)};
            RG_ERR_MAP:   rdata = {1'b0, ERR_FIXED};
            default:      rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
   import irqc_pkg::*;
#(
   parameter int N_SLOT  = 32,
   parameter int GRP     = 4,
   parameter int N_BOARD = 32,
   localparam int N_SRC  = N_SLOT + N_BOARD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [N_SRC-1:0]  req_vec
);
   localparam int N_SGRP = N_SLOT / GRP;
   localparam int SGW    = $clog2(N_SGRP);
   localparam int BW     = $clog2(N_BOARD);
   localparam int GW     = $clog2(GRP);
   localparam int SW     = $clog2(N_SLOT);
   localparam int XW     = $clog2(N_SRC);
   localparam int IW     = $clog2(N_SRC + 1);
   localparam logic [IW-1:0] IDLE = IW'(N_SRC);

   generate
      if (N_SLOT % GRP != 0) begin : g_bad_grp
         $error("irq_concentrator: N_SLOT must be a multiple of GRP");
      end
   endgenerate

   wr_event_t          ev;
   logic [SGW-1:0]     idx_sm, idx_sc;
   logic [BW-1:0]      idx_bm, idx_bc;
   logic [N_SGRP-1:0]  slot_en_q, slot_en_nx;
   logic [N_BOARD-1:0] board_en_q, board_en_nx;
   logic [N_SRC-1:0]   en_src_q, en_src_nx;
   logic [N_SRC-1:0]   pend_q;
   logic [IW-1:0]      req_q, req_d, req_a, req_boff;
   logic [SGW-1:0]     req_grp;
   logic               busy, req_is_slot, req_is_board;
   logic               drop, clr;
   logic               wr_en_bit, unused_wdata;

   assign wr_en_bit    = reg_wdata[EN_BIT];
   assign unused_wdata = ^reg_wdata[EN_BIT-1:0];

   irqc_regbank #(.N_SGRP(N_SGRP), .N_BOARD(N_BOARD), .GRP(GRP)) u_regs (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .wr_en_bit(wr_en_bit), .rdata(reg_rdata), .ev(ev),
      .idx_sm(idx_sm), .idx_bm(idx_bm), .idx_sc(idx_sc), .idx_bc(idx_bc),
      .slot_en_q(slot_en_q), .slot_en_nx(slot_en_nx),
      .board_en_q(board_en_q), .board_en_nx(board_en_nx)
   );

   generate
      for (genvar i = 0; i < N_SLOT; i++) begin : g_slot_src
         assign en_src_q[i]  = slot_en_q[i / GRP];
         assign en_src_nx[i] = slot_en_nx[i / GRP];
      end
      for (genvar j = 0; j < N_BOARD; j++) begin : g_board_src
         assign en_src_q[N_SLOT + j]  = board_en_q[j];
         assign en_src_nx[N_SLOT + j] = board_en_nx[j];
      end
   endgenerate

   logic              scan_found, srise_found, brise_found;
   logic [XW-1:0]     scan_idx;
   logic [SW-1:0]     srise_idx;
   logic [BW-1:0]     brise_idx;
   logic [N_SLOT-1:0] srise_vec;
   logic [N_BOARD-1:0] brise_vec;

   assign srise_vec = irq_in[N_SLOT-1:0] & ~pend_q[N_SLOT-1:0] & en_src_q[N_SLOT-1:0];
   assign brise_vec = irq_in[N_SRC-1:N_SLOT] & ~pend_q[N_SRC-1:N_SLOT] & en_src_q[N_SRC-1:N_SLOT];

   irqc_first_set #(.W(N_SRC)) u_scan (
      .vec(pend_q & en_src_nx), .found(scan_found), .idx(scan_idx)
   );
   irqc_first_set #(.W(N_SLOT)) u_srise (
      .vec(srise_vec), .found(srise_found), .idx(srise_idx)
   );
   irqc_first_set #(.W(N_BOARD)) u_brise (
      .vec(brise_vec), .found(brise_found), .idx(brise_idx)
   );

   assign busy         = (req_q != IDLE);
   assign req_is_slot  = (req_q < IW'(N_SLOT));
   assign req_is_board = busy && !req_is_slot;
   assign req_grp      = req_q[GW +: SGW];
   assign req_boff     = req_q - IW'(N_SLOT);

   always_comb begin
      drop = (ev.slot_map && !wr_en_bit && req_is_slot && (req_grp == idx_sm)) ||
             (ev.board_map && !wr_en_bit && req_is_board && (req_boff == IW'(idx_bm)));
      clr  = (ev.slot_clr && req_is_slot && (req_grp == idx_sc)) ||
             (ev.board_clr && req_is_board && (req_boff == IW'(idx_bc)));
      req_a = (drop || clr) ? IDLE : req_q;
      if ((ev.slot_map || ev.board_map || clr) && (req_a == IDLE) && scan_found) begin
         req_a = IW'(scan_idx);
      end
      if (srise_found) begin
         req_d = IW'(srise_idx);
      end else if ((req_a == IDLE) && brise_found) begin
         req_d = IW'(N_SLOT) + IW'(brise_idx);
      end else begin
         req_d = req_a;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         req_q  <= IDLE;
      end else begin
         pend_q <= irq_in;
         req_q  <= req_d;
      end
   end

   irqc_onehot #(.N(N_SRC), .IW(IW)) u_vec (.idx(req_q), .vec(req_vec));
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int N_SLOT  = 32,
   parameter int N_BOARD = 32,
   localparam int N_SRC  = N_SLOT + N_BOARD,
   localparam int BW     = $clog2(N_BOARD)
) (
   input logic              clk,
   input logic              rst,
   input logic [N_SRC-1:0]  irq_in,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [N_SRC-1:0]  req_vec,
   input logic [N_SRC-1:0]  en_src_q
);
   logic [N_SLOT-1:0] slot_prev;
   logic [N_SLOT-1:0] slot_rise_en;
   logic              unused_chk;

   assign unused_chk = ^{irq_in[N_SRC-1:N_SLOT], reg_addr[1:0],
                         reg_wdata[DATA_W-2:0], en_src_q[N_SRC-1:N_SLOT]};

   always_ff @(posedge clk) begin
      if (rst) slot_prev <= '0;
      else     slot_prev <= irq_in[N_SLOT-1:0];
   end

   assign slot_rise_en = irq_in[N_SLOT-1:0] & ~slot_prev & en_src_q[N_SLOT-1:0];

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_vec)); // R6

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (req_vec == '0)); // R1

   AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
      !reg_addr[UPPER_BIT] |-> (reg_rdata == '0)); // R3

   AST_REQUEST_HELD: assert property (@(posedge clk) disable iff (rst)
      (!reg_wr && (slot_rise_en == '0) && (req_vec != '0)) |=> $stable(req_vec)); // R6

   generate
      for (genvar j = 0; j < N_BOARD; j++) begin : g_drop
         AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr[UPPER_BIT] &&
             (reg_addr[REG_AW-1:REGION_LSB] == RG_BOARD_MAP) &&
             (reg_addr[STRIDE_LSB +: BW] == BW'(j)) && !reg_wdata[EN_BIT] &&
             req_vec[N_SLOT + j]) |=> !req_vec[N_SLOT + j]); // R9
      end
   endgenerate
endmodule

bind irq_concentrator irqc_checker #(.N_SLOT(N_SLOT), .N_BOARD(N_BOARD)) u_chk (
   .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_vec(req_vec),
   .en_src_q(en_src_q)
);

// File: tb/sim_irq_concentrator.sv
module sim_irq_concentrator;
   localparam int CLK_NS = 10;
   localparam int NV     = 25;
   localparam int IDLE_C = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] irq_in = '0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] req_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   irq_concentrator u0 (
      .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_vec(req_vec)
   );

   always #(CLK_NS / 2) clk = ~clk;

   // Entry: {tag[3:0], irq[63:0], wr, addr[11:0], en, expected source (64 = idle)}
   localparam logic [88:0] VTAB [NV] = '{
      {4'd10, 64'h0000_0000_0000_0000, 1'b1, 12'h004, 1'b1, 7'd64}, // R10 enable group 0, nothing pending
      {4'd4,  64'h0000_0000_0000_0002, 1'b0, 12'h000, 1'b0, 7'd1 }, // R4 slot 1 rises
      {4'd4,  64'h0000_0000_0000_000A, 1'b0, 12'h000, 1'b0, 7'd3 }, // R4 slot 3 takes over
      {4'd7,  64'h0000_0000_0000_000A, 1'b1, 12'h224, 1'b0, 7'd3 }, // R7 wrong group clear
      {4'd7,  64'h0000_0000_0000_000A, 1'b1, 12'h204, 1'b0, 7'd1 }, // R7 clear, rescan picks 1
      {4'd6,  64'h0000_0000_0000_0000, 1'b0, 12'h000, 1'b0, 7'd1 }, // R6 input falls, held
      {4'd7,  64'h0000_0000_0000_0000, 1'b1, 12'h204, 1'b0, 7'd64}, // R7 clear to idle
      {4'd10, 64'h0000_0000_0000_0000, 1'b1, 12'h12C, 1'b1, 7'd64}, // R10 enable board 5
      {4'd5,  64'h0000_0020_0000_0000, 1'b0, 12'h000, 1'b0, 7'd37}, // R5 board 5 rises idle
      {4'd10, 64'h0000_0020_0000_0000, 1'b1, 12'h134, 1'b1, 7'd37}, // R10 busy keeps request
      {4'd5,  64'h0000_0060_0000_0000, 1'b0, 12'h000, 1'b0, 7'd37}, // R5 board 6 rise ignored
      {4'd8,  64'h0000_0060_0000_0000, 1'b1, 12'h334, 1'b0, 7'd37}, // R8 wrong board clear
      {4'd8,  64'h0000_0060_0000_0000, 1'b1, 12'h32C, 1'b0, 7'd37}, // R8 clear, 37 still high
      {4'd6,  64'h0000_0040_0000_0000, 1'b0, 12'h000, 1'b0, 7'd37}, // R6 held after fall
      {4'd8,  64'h0000_0040_0000_0000, 1'b1, 12'h32C, 1'b0, 7'd38}, // R8 clear, rescan 38
      {4'd4,  64'h0000_0040_0000_0100, 1'b0, 12'h000, 1'b0, 7'd38}, // R4 disabled slot 8
      {4'd10, 64'h0000_0040_0000_0100, 1'b1, 12'h014, 1'b1, 7'd38}, // R10 enable group 2
      {4'd9,  64'h0000_0040_0000_0100, 1'b1, 12'h134, 1'b0, 7'd8 }, // R9 drop, slot first
      {4'd4,  64'h0000_0040_0000_0101, 1'b0, 12'h000, 1'b0, 7'd0 }, // R4 slot 0 takes over
      {4'd9,  64'h0000_0040_0000_0101, 1'b1, 12'h004, 1'b0, 7'd8 }, // R9 group 0 disabled
      {4'd10, 64'h0000_0040_0000_0001, 1'b1, 12'h134, 1'b1, 7'd8 }, // R10 busy keeps 8
      {4'd10, 64'h0000_0040_0000_0001, 1'b1, 12'h244, 1'b0, 7'd38}, // R10 rescan skips slot 0
      {4'd3,  64'h0000_0040_0000_0001, 1'b1, 12'h130, 1'b0, 7'd38}, // R3 low-word write ignored
      {4'd6,  64'h0000_0000_0000_0000, 1'b0, 12'h000, 1'b0, 7'd38}, // R6 held
      {4'd8,  64'h0000_0000_0000_0000, 1'b1, 12'h334, 1'b0, 7'd64}  // R8 clear to idle
   };

   function automatic logic [63:0] exp_vec(input int idx);
      return (idx >= IDLE_C) ? 64'd0 : (64'd1 << idx);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [63:0] irq, input logic wr, input logic [11:0] a,
                       input logic [31:0] d);
      @(negedge clk);
      irq_in = irq; reg_wr = wr; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 5000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_vec == '0, "R1 idle in reset", req_vec, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check(req_vec == '0, "R1 idle after reset", req_vec, 64'd0);
      rd(12'h004, 32'h0000_07C0, "R1 slot entry 0 after reset");
      rd(12'h1FC, 32'h0000_07FF, "R2 board entry 31 fixed value");

      for (int k = 0; k < NV; k++) begin
         logic [88:0] e;
         string       t;
         e = VTAB[k];
         step(e[84:21], e[20], e[19:8], {e[7], 31'h2AAA_AAAA});
         t = $sformatf("R%0d table step %0d", e[88:85], k + 1);
         check(req_vec == exp_vec(int'(e[6:0])), t, req_vec, exp_vec(int'(e[6:0])));
      end

      rd(12'h12C, 32'h8000_07E5, "R2 board entry 5 enabled");
      rd(12'h004, 32'h0000_07C0, "R2 slot entry 0 disabled");
      rd(12'h014, 32'h8000_07C8, "R2 slot entry 2 enabled");
      rd(12'h128, 32'h0000_0000, "R3 low word reads zero");
      rd(12'h404, 32'h0000_07F0, "R11 error entry 0");
      step(64'd0, 1'b1, 12'h40C, 32'hFFFF_FFFF);
      rd(12'h40C, 32'h0000_07F0, "R11 error entry 1 write ignored");
      step(64'd0, 1'b1, 12'h12C, 32'h7FFF_FFFF);
      rd(12'h12C, 32'h0000_07E5, "R2 write touches only bit 31");
      step(64'd0, 1'b1, 12'h134, 32'hFFFF_FFFF);
      rd(12'h134, 32'h8000_07E6, "R2 enable set with all ones");

      step(64'd0, 1'b1, 12'h1FC, 32'h8000_0000);
      step(64'h8000_0000_0000_0000, 1'b0, 12'h000, 32'd0);
      check(req_vec == exp_vec(63), "R12 top source bit", req_vec, exp_vec(63));

      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(req_vec == '0, "R1 mid-run reset clears request", req_vec, 64'd0);
      rst = 1'b0;
      rd(12'h1FC, 32'h0000_07FF, "R1 enable cleared, low bits kept");
      rd(12'h034, 32'h0000_07D8, "R1 slot entry 6 value");
      check(req_vec == '0, "R1 held input not requested after reset", req_vec, 64'd0);

      step(64'h8000_0000_0000_0000, 1'b1, 12'h00C, 32'h8000_0000);
      step(64'h8000_0000_0000_0000, 1'b1, 12'h03C, 32'h8000_0000);
      step(64'h8000_0000_4000_0020, 1'b0, 12'h000, 32'd0);
      check(req_vec == exp_vec(5), "R4 lowest simultaneous slot wins", req_vec, exp_vec(5));

      report();
   end
endmodule